// File: doc/BRIEF.md
# PHY Power-Up Calibration Sequencer

This block is a hardware state machine that takes a storage-interface PHY out of power-down when a start pulse arrives. At start it captures a requested output drive strength (in ohms) and the measured interface clock frequency (in Hz). It then runs a fixed, ordered sequence:

1. Program the drive code and turn on the output tap delay.
2. Force PHY power and DLL enable off, wait a minimum off time, and power the PHY back up.
3. Poll calibration-done a bounded number of times.
4. Write the frequency band and enable the DLL.
5. Poll DLL-ready a bounded number of times, unless the frequency is unknown (zero).

All timing comes from a one-microsecond tick input. The millisecond gap between DLL polls is counted as a parameterised number of ticks. A faster tick therefore shortens every wait in proportion.

The PHY control fields are held in registers and keep their values between runs. A one-cycle done pulse ends each sequence. Two sticky flags report a calibration timeout and a DLL timeout. A missed calibration does not stop the sequence. All pins are plain control and status levels or pulses, with no handshake. While the block is busy it does not accept a new start; a start pulse seen while busy is dropped, not queued.

Top module: `phy_cal_seq`

## Requirements
- R1: The drive code is taken from the ohm value captured at start: 100→3, 66→2, 50→0, 40→4, 33→1. Any other value gives 0 (the 50 ohm code). The code reaches `drv_code_o` before power is cycled.
- R2: The band code is taken from the frequency captured at start and is written to `band_o`. A frequency of 0 gives 0 (200 MHz band). Otherwise: below 75 000 000 gives 1 (50 MHz), below 125 000 000 gives 2 (100 MHz), below 175 000 000 gives 3 (150 MHz), and any higher value gives 0 (200 MHz).
- R3: When `pwr_on_o` rises, `tap_en_o` is 1 and `tap_sel_o` equals 4.
- R4: Each run forces `pwr_on_o` and `dll_en_o` to 0. `pwr_on_o` returns to 1 only after PWR_US+1 = 4 tick pulses have been seen with power off. `dll_en_o` stays 0 at that point.
- R5: Calibration-done is sampled at most 5 times, with 10 ticks between samples. With one tick per cycle, the samples fall at cycles 1, 12, 23, 34 and 45 after `pwr_on_o` rises. If it is never seen, `cal_tmo_o` is set and the sequence still goes on.
- R6: `band_o` and `dll_en_o` keep their previous values until the calibration wait has finished.
- R7: With a nonzero frequency, DLL-ready is sampled at most 5 times, with 10×1000 ticks between samples. If it is never seen, `dll_tmo_o` is set.
- R8: With a frequency of 0, the DLL wait is skipped. The run ends within a few cycles after the DLL is enabled, and `dll_tmo_o` stays 0.
- R9: `done_o` is high for exactly one cycle per accepted start. A start seen while `busy_o` is high (including the done cycle) has no effect: no extra run, and no change to the captured inputs.
- R10: `cal_tmo_o` and `dll_tmo_o` hold their value after the run ends. They clear when the next start is accepted.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| imp_ohm_i | input | IMP_W | Requested drive impedance in ohms |
| freq_hz_i | input | FREQ_W | Interface clock frequency in Hz, 0 = unknown |
| cal_done_i | input | 1 | PHY calibration complete |
| dll_rdy_i | input | 1 | PHY DLL locked |
| drv_code_o | output | 3 | Drive strength code |
| tap_en_o | output | 1 | Output tap delay enable |
| tap_sel_o | output | TAP_W | Output tap delay value |
| pwr_on_o | output | 1 | PHY power enable |
| dll_en_o | output | 1 | DLL enable |
| band_o | output | 2 | Frequency band code |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| cal_tmo_o | output | 1 | Sticky calibration timeout |
| dll_tmo_o | output | 1 | Sticky DLL timeout |

## Verification
Calibration completing and the retry budget running out can land on the same cycle. That happens when calibration-done first goes high just in time for the fifth and last sample. The bench provokes this with a calibration delay of 44 cycles, which must count as success, and 45 cycles, which must raise the timeout. The second same-cycle case is a start pulse driven during the done cycle. The bench judges it as correctly ignored if `busy_o` stays low and no second done pulse reaches the scoreboard.

// File: rtl/phy_cal_pkg.sv
package phy_cal_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CFG,
    ST_PDN,
    ST_PWAIT,
    ST_CAL_CHK,
    ST_CAL_WAIT,
    ST_BAND,
    ST_DLL_ON,
    ST_DLL_CHK,
    ST_DLL_WAIT,
    ST_FIN
  } seq_state_e;

  // drive strength codes
  localparam logic [2:0] DRV_50R  = 3'd0;
  localparam logic [2:0] DRV_33R  = 3'd1;
  localparam logic [2:0] DRV_66R  = 3'd2;
  localparam logic [2:0] DRV_100R = 3'd3;
  localparam logic [2:0] DRV_40R  = 3'd4;

  // frequency band codes
  localparam logic [1:0] BAND_200 = 2'd0;
  localparam logic [1:0] BAND_50  = 2'd1;
  localparam logic [1:0] BAND_100 = 2'd2;
  localparam logic [1:0] BAND_150 = 2'd3;

endpackage

// File: rtl/phy_cal_imp_map.sv
module phy_cal_imp_map
  import phy_cal_pkg::*;
#(
  parameter int IMP_W = 8
) (
  input  logic [IMP_W-1:0] ohm_i,
  output logic [2:0]       code_o
);

  always_comb begin
    case (ohm_i)
      IMP_W'(100): code_o = DRV_100R;
      IMP_W'(66):  code_o = DRV_66R;
      IMP_W'(50):  code_o = DRV_50R;
      IMP_W'(40):  code_o = DRV_40R;
      IMP_W'(33):  code_o = DRV_33R;
      default:     code_o = DRV_50R;  // unsupported request: R1 fallback
    endcase
  end

endmodule

// File: rtl/phy_cal_band_map.sv
module phy_cal_band_map
  import phy_cal_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int LIM_50  = 75_000_000,
  parameter int LIM_100 = 125_000_000,
  parameter int LIM_150 = 175_000_000
) (
  input  logic [FREQ_W-1:0] freq_i,
  output logic [1:0]        band_o
);

  localparam logic [FREQ_W-1:0] L50  = FREQ_W'(LIM_50);
  localparam logic [FREQ_W-1:0] L100 = FREQ_W'(LIM_100);
  localparam logic [FREQ_W-1:0] L150 = FREQ_W'(LIM_150);

  always_comb begin
    if (freq_i == '0)      band_o = BAND_200;  // unknown clock
    else if (freq_i < L50)  band_o = BAND_50;
    else if (freq_i < L100) band_o = BAND_100;
    else if (freq_i < L150) band_o = BAND_150;
    else                    band_o = BAND_200;
  end

endmodule

// File: rtl/phy_cal_timer.sv
module phy_cal_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = !clr_i && tick_i && (cnt_q == target_i - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (expire_o)   cnt_q <= '0;
    else if (tick_i)     cnt_q <= cnt_q + CNT_W'(1);
  end

  // R4: wait time advances only on microsecond ticks
  assert_timer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/phy_cal_seq.sv
module phy_cal_seq
  import phy_cal_pkg::*;
#(
  parameter int IMP_W      = 8,
  parameter int FREQ_W     = 32,
  parameter int TAP_W      = 4,
  parameter int TAP_VAL    = 4,
  parameter int PWR_US     = 3,
  parameter int CAL_TRIES  = 5,
  parameter int CAL_GAP_US = 10,
  parameter int DLL_TRIES  = 5,
  parameter int DLL_GAP_MS = 10,
  parameter int US_PER_MS  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              us_tick_i,
  input  logic [IMP_W-1:0]  imp_ohm_i,
  input  logic [FREQ_W-1:0] freq_hz_i,
  input  logic              cal_done_i,
  input  logic              dll_rdy_i,
  output logic [2:0]        drv_code_o,
  output logic              tap_en_o,
  output logic [TAP_W-1:0]  tap_sel_o,
  output logic              pwr_on_o,
  output logic              dll_en_o,
  output logic [1:0]        band_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              cal_tmo_o,
  output logic              dll_tmo_o
);

  localparam int PWR_TICKS = PWR_US + 1;           // guarantees a full PWR_US off time
  localparam int DLL_TICKS = DLL_GAP_MS * US_PER_MS;
  localparam int MAX_TICKS = (DLL_TICKS > CAL_GAP_US) ?
                             ((DLL_TICKS > PWR_TICKS) ? DLL_TICKS : PWR_TICKS) :
                             ((CAL_GAP_US > PWR_TICKS) ? CAL_GAP_US : PWR_TICKS);
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam int MAX_TRY   = (CAL_TRIES > DLL_TRIES) ? CAL_TRIES : DLL_TRIES;
  localparam int TRY_W     = $clog2(MAX_TRY + 1);

  seq_state_e        state_q;
  logic [IMP_W-1:0]  imp_q;
  logic [FREQ_W-1:0] freq_q;
  logic [TRY_W-1:0]  tries_q;
  logic [2:0]        drv_q;
  logic              tap_en_q;
  logic [TAP_W-1:0]  tap_sel_q;
  logic              pwr_on_q;
  logic              dll_en_q;
  logic [1:0]        band_q;
  logic              cal_tmo_q;
  logic              dll_tmo_q;

  logic [2:0]        drv_map;
  logic [1:0]        band_map;
  logic              in_wait;
  logic [CNT_W-1:0]  wait_target;
  logic              wait_expire;

  phy_cal_imp_map #(.IMP_W(IMP_W)) u_imp_map (
    .ohm_i  (imp_q),
    .code_o (drv_map)
  );

  phy_cal_band_map #(.FREQ_W(FREQ_W)) u_band_map (
    .freq_i (freq_q),
    .band_o (band_map)
  );

  always_comb begin
    in_wait     = 1'b1;
    wait_target = CNT_W'(PWR_TICKS);
    case (state_q)
      ST_PWAIT:    wait_target = CNT_W'(PWR_TICKS);
      ST_CAL_WAIT: wait_target = CNT_W'(CAL_GAP_US);
      ST_DLL_WAIT: wait_target = CNT_W'(DLL_TICKS);
      default:     in_wait     = 1'b0;
    endcase
  end

  phy_cal_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (!in_wait),
    .tick_i   (us_tick_i),
    .target_i (wait_target),
    .expire_o (wait_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      imp_q     <= '0;
      freq_q    <= '0;
      tries_q   <= '0;
      drv_q     <= '0;
      tap_en_q  <= 1'b0;
      tap_sel_q <= '0;
      pwr_on_q  <= 1'b0;
      dll_en_q  <= 1'b0;
      band_q    <= '0;
      cal_tmo_q <= 1'b0;
      dll_tmo_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            imp_q     <= imp_ohm_i;
            freq_q    <= freq_hz_i;
            cal_tmo_q <= 1'b0;
            dll_tmo_q <= 1'b0;
            state_q   <= ST_CFG;
          end
        end
        ST_CFG: begin
          drv_q     <= drv_map;
          tap_en_q  <= 1'b1;
          tap_sel_q <= TAP_W'(TAP_VAL);
          state_q   <= ST_PDN;
        end
        ST_PDN: begin
          pwr_on_q <= 1'b0;
          dll_en_q <= 1'b0;
          state_q  <= ST_PWAIT;
        end
        ST_PWAIT: begin
          if (wait_expire) begin
            pwr_on_q <= 1'b1;
            tries_q  <= '0;
            state_q  <= ST_CAL_CHK;
          end
        end
        ST_CAL_CHK: begin
          if (cal_done_i) begin
            state_q <= ST_BAND;
          end else if (tries_q == TRY_W'(CAL_TRIES - 1)) begin
            cal_tmo_q <= 1'b1;
            state_q   <= ST_BAND;
          end else begin
            tries_q <= tries_q + TRY_W'(1);
            state_q <= ST_CAL_WAIT;
          end
        end
        ST_CAL_WAIT: begin
          if (wait_expire) state_q <= ST_CAL_CHK;
        end
        ST_BAND: begin
          band_q  <= band_map;
          state_q <= ST_DLL_ON;
        end
        ST_DLL_ON: begin
          dll_en_q <= 1'b1;
          tries_q  <= '0;
          state_q  <= (freq_q == '0) ? ST_FIN : ST_DLL_CHK;
        end
        ST_DLL_CHK: begin
          if (dll_rdy_i) begin
            state_q <= ST_FIN;
          end else if (tries_q == TRY_W'(DLL_TRIES - 1)) begin
            dll_tmo_q <= 1'b1;
            state_q   <= ST_FIN;
          end else begin
            tries_q <= tries_q + TRY_W'(1);
            state_q <= ST_DLL_WAIT;
          end
        end
        ST_DLL_WAIT: begin
          if (wait_expire) state_q <= ST_DLL_CHK;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign drv_code_o = drv_q;
  assign tap_en_o   = tap_en_q;
  assign tap_sel_o  = tap_sel_q;
  assign pwr_on_o   = pwr_on_q;
  assign dll_en_o   = dll_en_q;
  assign band_o     = band_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FIN);
  assign cal_tmo_o  = cal_tmo_q;
  assign dll_tmo_o  = dll_tmo_q;

  assert_tap_before_pwr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on_q) |-> (tap_en_q && tap_sel_q == TAP_W'(TAP_VAL)));

  assert_pwr_off_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PWAIT) |-> (!pwr_on_q && !dll_en_q));

  assert_try_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CAL_WAIT) |-> (tries_q <= TRY_W'(CAL_TRIES - 1)));

  assert_dll_after_pwr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_en_q) |-> pwr_on_q);

  assert_dll_tmo_needs_freq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_tmo_q) |-> (freq_q != '0));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(cal_tmo_q) && $stable(dll_tmo_q)));

endmodule

// File: tb/phy_cal_seq_bench.sv
module phy_cal_seq_bench;

  localparam int NEVER = 1_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        us_tick_i;
  logic [7:0]  imp_ohm_i = '0;
  logic [31:0] freq_hz_i = '0;
  logic        cal_done_i;
  logic        dll_rdy_i;
  logic [2:0]  drv_code_o;
  logic        tap_en_o;
  logic [3:0]  tap_sel_o;
  logic        pwr_on_o;
  logic        dll_en_o;
  logic [1:0]  band_o;
  logic        busy_o;
  logic        done_o;
  logic        cal_tmo_o;
  logic        dll_tmo_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tick_per = 1;
  int tick_cnt = 0;
  int cal_delay = 0;
  int dll_delay = 0;
  int cal_cnt = 0;
  int dll_cnt = 0;

  typedef struct {
    logic [2:0] drv;
    logic [1:0] band;
    logic       cal_tmo;
    logic       dll_tmo;
    string      tmo_req;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;  // 200 MHz

  phy_cal_seq u_phy_cal_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .us_tick_i(us_tick_i),
    .imp_ohm_i(imp_ohm_i), .freq_hz_i(freq_hz_i), .cal_done_i(cal_done_i),
    .dll_rdy_i(dll_rdy_i), .drv_code_o(drv_code_o), .tap_en_o(tap_en_o),
    .tap_sel_o(tap_sel_o), .pwr_on_o(pwr_on_o), .dll_en_o(dll_en_o),
    .band_o(band_o), .busy_o(busy_o), .done_o(done_o), .cal_tmo_o(cal_tmo_o),
    .dll_tmo_o(dll_tmo_o)
  );

  // PHY model: ready levels after a configurable number of cycles
  always @(posedge clk) begin
    cyc <= cyc + 1;
    cal_cnt <= pwr_on_o ? cal_cnt + 1 : 0;
    dll_cnt <= dll_en_o ? dll_cnt + 1 : 0;
  end
  assign cal_done_i = pwr_on_o && (cal_cnt >= cal_delay);
  assign dll_rdy_i  = dll_en_o && (dll_cnt >= dll_delay);

  always @(negedge clk) tick_cnt <= (tick_cnt + 1 >= tick_per) ? 0 : tick_cnt + 1;
  assign us_tick_i = (tick_cnt == 0);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [2:0] exp_drv(input int ohm);
    case (ohm)
      100: return 3'd3;
      66:  return 3'd2;
      50:  return 3'd0;
      40:  return 3'd4;
      33:  return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [1:0] exp_band(input logic [31:0] f);
    if (f == 0) return 2'd0;
    if (f < 75_000_000) return 2'd1;
    if (f < 125_000_000) return 2'd2;
    if (f < 175_000_000) return 2'd3;
    return 2'd0;
  endfunction

  // driver: pushes expectation, issues start, waits for the end of the run
  task automatic run_seq(input int ohm, input logic [31:0] f, input int cd, input int dd,
                         input bit ecal, input bit edll, input string treq);
    exp_t e;
    e.drv = exp_drv(ohm); e.band = exp_band(f);
    e.cal_tmo = ecal; e.dll_tmo = edll; e.tmo_req = treq;
    sb_q.push_back(e);
    @(negedge clk);
    cal_delay = cd; dll_delay = dd;
    imp_ohm_i = 8'(ohm); freq_hz_i = f; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    do @(negedge clk); while (busy_o);
  endtask

  // monitor: compare at each done pulse
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected done pulse", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(drv_code_o == e.drv, "R1", "drive code", drv_code_o, e.drv);
        chk(band_o == e.band, "R2", "band code", band_o, e.band);
        chk(tap_en_o && tap_sel_o == 4, "R3", "tap select at done", tap_sel_o, 4);
        chk(cal_tmo_o == e.cal_tmo, "R5", "cal timeout flag", cal_tmo_o, e.cal_tmo);
        chk(dll_tmo_o == e.dll_tmo, e.tmo_req, "dll timeout flag", dll_tmo_o, e.dll_tmo);
        chk(pwr_on_o && dll_en_o, "R6", "power and dll on at done", {pwr_on_o, dll_en_o}, 3);
      end
    end
  end

  // power-cycle monitor
  bit prev_pwr = 1'b0;
  bit measuring = 1'b0;
  int off_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_pwr && !pwr_on_o) begin measuring = 1'b1; off_cnt = 0; end
      if (measuring && !pwr_on_o) off_cnt++;
      if (!prev_pwr && pwr_on_o) begin
        chk(tap_en_o && tap_sel_o == 4, "R3", "tap at power-up", tap_sel_o, 4);
        chk(!dll_en_o, "R4", "dll off at power-up", dll_en_o, 0);
        if (measuring)
          chk(off_cnt >= 3 * tick_per + 1, "R4", "power-off cycles", off_cnt, 3 * tick_per + 1);
        measuring = 1'b0;
      end
      prev_pwr = pwr_on_o;
    end
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    chk({drv_code_o, tap_en_o, tap_sel_o, pwr_on_o, dll_en_o, band_o, busy_o, done_o,
         cal_tmo_o, dll_tmo_o} == '0, "R11", "reset outputs", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_seq(100, 100_000_000, 0, 3, 0, 0, "R7");
    run_seq(66, 50_000_000, 30, 0, 0, 0, "R7");

    // R6: band and dll enable untouched during the calibration wait
    fork
      run_seq(40, 160_000_000, NEVER, 0, 1, 0, "R7");
      begin
        @(posedge pwr_on_o);
        repeat (20) @(negedge clk);
        chk(band_o == 2'd1, "R6", "band held during cal wait", band_o, 1);
        chk(!dll_en_o, "R6", "dll off during cal wait", dll_en_o, 0);
      end
    join

    // R10: flag holds while idle, clears at next start
    repeat (20) @(negedge clk);
    chk(cal_tmo_o == 1'b1, "R10", "cal flag held", cal_tmo_o, 1);
    fork
      run_seq(33, 200_000_000, 44, 0, 0, 0, "R7");  // R5 last-sample success
      begin
        @(posedge busy_o); @(negedge clk);
        chk(cal_tmo_o == 1'b0, "R10", "cal flag cleared at start", cal_tmo_o, 0);
      end
    join

    run_seq(50, 74_999_999, 45, 0, 1, 0, "R7");     // R5 one cycle too late
    run_seq(77, 75_000_000, 0, 0, 0, 0, "R7");      // R1 default, R2 boundary
    run_seq(0, 125_000_000, 0, 0, 0, 0, "R7");
    run_seq(0, 174_999_999, 0, 0, 0, 0, "R7");
    run_seq(0, 175_000_000, 0, 0, 0, 0, "R7");

    // R8: zero frequency skips dll wait
    t0 = cyc;
    run_seq(100, 0, 0, NEVER, 0, 0, "R8");
    chk(cyc - t0 < 40, "R8", "short run without dll wait", cyc - t0, 40);

    // R9: start while busy ignored
    fork
      run_seq(100, 100_000_000, 0, 0, 0, 0, "R7");
      begin
        repeat (6) @(negedge clk);
        imp_ohm_i = 8'd33; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
      end
    join

    // R9: start on the done cycle ignored
    fork
      run_seq(66, 100_000_000, 0, 0, 0, 0, "R7");
      begin
        do @(negedge clk); while (!done_o);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o, "R9", "start on done cycle ignored", busy_o, 0);
      end
    join
    repeat (10) @(negedge clk);
    chk(!busy_o, "R9", "still idle", busy_o, 0);

    // R4: slower tick stretches the power-off time
    tick_per = 2;
    run_seq(40, 60_000_000, 0, 0, 0, 0, "R7");
    tick_per = 1;

    // R7: dll never locks
    run_seq(50, 100_000_000, 0, NEVER, 0, 1, "R7");
    repeat (5) @(negedge clk);
    chk(dll_tmo_o == 1'b1, "R10", "dll flag held", dll_tmo_o, 1);

    chk(sb_q.size() == 0, "R9", "all expected done pulses seen", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 150_000);
    chk(1'b0, "R9", "watchdog expired", cyc, 150_000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule